// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects up to eight interrupt request lines, ranks them by a fixed priority (line 0 first) and raises a single interrupt output toward a processor. The processor answers with an acknowledge pulse. The controller then returns an 8-bit vector built from a programmable base and the winning line number. It also marks that line as being serviced, so lines of equal or lower priority stay blocked until the service is ended.

Software reaches the controller through a byte-wide bus with two addresses: a command port and a data port. A command write with bit 4 set starts a setup sequence. The setup words that follow on the data port set the vector base and select single or paired operation. They also choose whether a final mode word is sent, and that word can switch on automatic end-of-service. Outside setup, data writes load the mask. Command writes end a service, either for one named line or for all lines, or they arm a one-shot read of the in-service register.

Top module: `pic8_ctrl`

## Requirements
- R1: After the synchronous reset the request and in-service registers are 0, the mask is 0xFF, the vector output is 0, the interrupt output is low, and the controller is not in setup.
- R2: A command write with bit 4 set enters setup and records bit 1 (1 = single) and bit 0 (1 = mode word follows). The next data write sets the vector base to its bits 7:3. Vector bits 2:0 always come from the line number.
- R3: When setup selected single and no mode word, setup ends after the base word, and the following data write loads the mask.
- R4: When setup selected paired operation, the data write after the base word is the link word. It has no other effect, and setup ends there unless a mode word was requested.
- R5: The mode word is the last setup write. Its bit 1 enables automatic end-of-service, so an acknowledge no longer sets an in-service bit.
- R6: A data write outside setup loads the mask. A data write during setup leaves the mask unchanged. A data read returns the mask one cycle after the read strobe.
- R7: A command write of exactly 0x0B makes the next command read, and only that one, return the in-service register. Every other command read returns the request register.
- R8: A command write with bits 4:3 = 00 and bit 5 set ends service. If bit 6 is also set, it clears only the in-service bit numbered by bits 2:0. If bit 6 is clear, it clears the whole in-service register.
- R9: A rising edge on a request input sets its request bit. One cycle after the registers change, the interrupt output is high exactly when some request bit is unmasked and no in-service bit at the same or a lower index is set.
- R10: An acknowledge takes the lowest-index eligible request, clears its request bit, and sets its in-service bit unless automatic end-of-service is on. On the next cycle the vector output shows the base followed by the line number.
- R11: An acknowledge with no eligible request returns the base followed by 7 and changes neither the request nor the in-service register.
- R12: When several eligible requests are pending, the lowest index wins. A higher-index request stays blocked while a lower in-service bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Port select: 0 command, 1 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| irq_in | input | DW | Request lines, rising-edge sensitive |
| irq_out | output | 1 | Interrupt output to the processor |
| int_ack | input | 1 | Acknowledge pulse from the processor |
| vec_out | output | DW | Vector captured on acknowledge |

## Verification
The hardest state to reach is a nested case. A lower-index line is in service, and a higher-index request waits behind it. A new rising edge must also be produced on a line that is already high without re-triggering its neighbours. The stimulus raises lines one at a time and holds the older lines high, so only the intended line sees a new edge. It then acknowledges again while service is still open, which must give the spurious vector. Setup variants are reached by running the single, paired and paired-plus-mode sequences in turn, and reading the mask between setup words.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_LINK, ST_MODE} init_st_t;

  localparam int        SETUP_BIT  = 4;
  localparam int        READSEL_BIT = 3;
  localparam int        EOI_BIT    = 5;
  localparam int        SPEC_BIT   = 6;
  localparam int        SINGLE_BIT = 1;
  localparam int        MODEW_BIT  = 0;
  localparam int        AUTO_BIT   = 1;
  localparam logic [7:0] SHOW_ISR_CODE = 8'h0B;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N  = 8,
  parameter int LW = 3
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [LW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = LW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cmd,
  input  logic             wr_dat,
  input  logic             rd_cmd,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    mask_q,
  output logic [DW-LW-1:0] base_q,
  output logic             aeoi_q,
  output logic             in_init,
  output logic             show_isr,
  output logic             eoi_all,
  output logic             eoi_one,
  output logic [LW-1:0]    eoi_lvl
);
  init_st_t st_q;
  logic     single_q, need_mode_q;
  logic     is_setup, is_rdsel, is_svc;

  assign is_setup = wdata[SETUP_BIT];
  assign is_rdsel = !wdata[SETUP_BIT] && wdata[READSEL_BIT];
  assign is_svc   = !wdata[SETUP_BIT] && !wdata[READSEL_BIT];
  assign eoi_all  = wr_cmd && is_svc && wdata[EOI_BIT] && !wdata[SPEC_BIT];
  assign eoi_one  = wr_cmd && is_svc && wdata[EOI_BIT] && wdata[SPEC_BIT];
  assign eoi_lvl  = wdata[LW-1:0];
  assign in_init  = (st_q != ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_RUN;
      mask_q      <= '1;
      base_q      <= '0;
      aeoi_q      <= 1'b0;
      single_q    <= 1'b0;
      need_mode_q <= 1'b0;
      show_isr    <= 1'b0;
    end else begin
      if (wr_cmd && is_setup) begin
        st_q        <= ST_BASE;
        single_q    <= wdata[SINGLE_BIT];
        need_mode_q <= wdata[MODEW_BIT];
      end
      if (wr_cmd && is_rdsel && wdata == SHOW_ISR_CODE)
        show_isr <= 1'b1;
      else if (rd_cmd)
        show_isr <= 1'b0;
      if (wr_dat) begin
        case (st_q)
          ST_RUN:  mask_q <= wdata;
          ST_BASE: begin
            base_q <= wdata[DW-1:LW];
            if (!single_q)       st_q <= ST_LINK;
            else if (need_mode_q) st_q <= ST_MODE;
            else                  st_q <= ST_RUN;
          end
          ST_LINK: st_q <= need_mode_q ? ST_MODE : ST_RUN;
          default: begin
            aeoi_q <= wdata[AUTO_BIT];
            st_q   <= ST_RUN;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_core.sv
module pic_core #(
  parameter int N  = 8,
  parameter int LW = 3,
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_in,
  input  logic [N-1:0]  mask,
  input  logic [BW-1:0] base,
  input  logic          aeoi,
  input  logic          ack,
  input  logic          eoi_all,
  input  logic          eoi_one,
  input  logic [LW-1:0] eoi_lvl,
  output logic [N-1:0]  irr_q,
  output logic [N-1:0]  isr_q,
  output logic          irq_out,
  output logic [N-1:0]  vec_out
);
  logic [N-1:0]  req_q, rise, busy, elig, pick_oh, eoi_clr;
  logic          hit;
  logic [LW-1:0] idx;

  always_comb begin : busy_scan
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < N; i++) begin
      acc     = acc | isr_q[i];
      busy[i] = acc;
    end
  end

  assign rise = irq_in & ~req_q;
  assign elig = irr_q & ~mask & ~busy;

  pic_prio #(.N(N), .LW(LW)) u_pick (
    .req (elig),
    .hit (hit),
    .idx (idx)
  );

  assign pick_oh = hit ? (N'(1) << idx) : '0;
  assign eoi_clr = eoi_all ? '1 : (eoi_one ? (N'(1) << eoi_lvl) : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= '0;
      irr_q   <= '0;
      isr_q   <= '0;
      irq_out <= 1'b0;
      vec_out <= '0;
    end else begin
      req_q   <= irq_in;
      irr_q   <= (irr_q & ~(ack ? pick_oh : '0)) | rise;
      isr_q   <= (isr_q & ~eoi_clr) | ((ack && !aeoi) ? pick_oh : '0);
      irq_out <= |elig;
      if (ack)
        vec_out <= hit ? {base, idx} : {base, {LW{1'b1}}};
    end
  end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] irq_in,
  output logic          irq_out,
  input  logic          int_ack,
  output logic [DW-1:0] vec_out
);
  localparam int LW = $clog2(DW);
  localparam int BW = DW - LW;

  logic [DW-1:0] mask_q, irr_q, isr_q;
  logic [BW-1:0] base_q;
  logic          aeoi_q, in_init, show_isr, eoi_all, eoi_one;
  logic [LW-1:0] eoi_lvl;

  pic_cfg #(.DW(DW), .LW(LW)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_cmd   (wr_en && !bus_sel),
    .wr_dat   (wr_en && bus_sel),
    .rd_cmd   (rd_en && !bus_sel),
    .wdata    (wdata),
    .mask_q   (mask_q),
    .base_q   (base_q),
    .aeoi_q   (aeoi_q),
    .in_init  (in_init),
    .show_isr (show_isr),
    .eoi_all  (eoi_all),
    .eoi_one  (eoi_one),
    .eoi_lvl  (eoi_lvl)
  );

  pic_core #(.N(DW), .LW(LW), .BW(BW)) u_core (
    .clk     (clk),
    .rst     (rst),
    .irq_in  (irq_in),
    .mask    (mask_q),
    .base    (base_q),
    .aeoi    (aeoi_q),
    .ack     (int_ack),
    .eoi_all (eoi_all),
    .eoi_one (eoi_one),
    .eoi_lvl (eoi_lvl),
    .irr_q   (irr_q),
    .isr_q   (isr_q),
    .irq_out (irq_out),
    .vec_out (vec_out)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= bus_sel ? mask_q : (show_isr ? isr_q : irr_q);
  end
endmodule

// File: rtl/pic8_ctrl_chk.sv
module pic8_ctrl_chk #(
  parameter int DW = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_sel,
  input logic                      wr_en,
  input logic [3:0]                op_bits,
  input logic                      int_ack,
  input logic                      irq_out,
  input logic [DW-1:0]             vec_out,
  input logic [DW-1:0]             mask,
  input logic [DW-$clog2(DW)-1:0]  base,
  input logic [DW-1:0]             isr,
  input logic [DW-1:0]             irr,
  input logic                      aeoi,
  input logic                      in_init
);
  localparam int LW = $clog2(DW);

  // op_bits = wdata[6:3]
  a_r1_post_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask == '1 && isr == '0 && irr == '0 && !in_init));

  a_r10_vec_base: assert property (@(posedge clk) disable iff (rst)
    int_ack |=> (vec_out[DW-1:LW] == $past(base)));

  a_r9_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|(irr & ~mask)));

  a_r8_eoi_all: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !bus_sel && op_bits[1:0] == 2'b00 && op_bits[2] && !op_bits[3] && !int_ack)
      |=> (isr == '0));

  a_r6_init_mask: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bus_sel && in_init) |=> $stable(mask));

  a_r5_aeoi_isr: assert property (@(posedge clk) disable iff (rst)
    (aeoi && int_ack && !wr_en) |=> $stable(isr));
endmodule

bind pic8_ctrl pic8_ctrl_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_sel (bus_sel),
  .wr_en   (wr_en),
  .op_bits (wdata[6:3]),
  .int_ack (int_ack),
  .irq_out (irq_out),
  .vec_out (vec_out),
  .mask    (mask_q),
  .base    (base_q),
  .isr     (isr_q),
  .irr     (irr_q),
  .aeoi    (aeoi_q),
  .in_init (in_init)
);

// File: tb/pic8_ctrl_tb.sv
module pic8_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, int_ack = 1'b0;
  logic [7:0] wdata = 8'h00, irq_in = 8'h00;
  logic [7:0] rdata, vec_out;
  logic       irq_out;

  int    checks = 0, errors = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic8_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .irq_out(irq_out),
    .int_ack(int_ack), .vec_out(vec_out)
  );

  // behavioural reference model
  int m_irr, m_isr, m_mask, m_base, m_phase, m_single, m_mode, m_aeoi, m_show;
  int m_reqq, m_irq, m_vec, m_rdata;

  function automatic int eligible();
    int low = 8;
    int e = 0;
    for (int i = 7; i >= 0; i--) if ((m_isr >> i) & 1) low = i;
    for (int i = 0; i < low; i++)
      if (((m_irr >> i) & 1) && !((m_mask >> i) & 1)) e |= (1 << i);
    return e;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_irr = 0; m_isr = 0; m_mask = 8'hFF; m_base = 0; m_phase = 0;
      m_single = 0; m_mode = 0; m_aeoi = 0; m_show = 0;
      m_reqq = 0; m_irq = 0; m_vec = 0; m_rdata = 0;
    end else begin
      int e, win, n_irr, n_isr;
      e = eligible();
      win = -1;
      for (int i = 7; i >= 0; i--) if ((e >> i) & 1) win = i;
      n_irr = m_irr; n_isr = m_isr;
      if (rd_en) begin
        if (bus_sel) m_rdata = m_mask;
        else m_rdata = m_show ? m_isr : m_irr;
      end
      if (int_ack) begin
        if (win >= 0) begin
          n_irr &= ~(1 << win);
          if (!m_aeoi) n_isr |= (1 << win);
          m_vec = m_base * 8 + win;
        end else m_vec = m_base * 8 + 7;
      end
      n_irr |= irq_in & ~m_reqq;
      if (wr_en && !bus_sel) begin
        if (wdata[4]) begin
          m_phase = 1; m_single = wdata[1]; m_mode = wdata[0];
        end else if (wdata[3]) begin
          if (wdata == 8'h0B) m_show = 1;
        end else if (wdata[5]) begin
          if (wdata[6]) n_isr &= ~(1 << wdata[2:0]);
          else n_isr = 0;
        end
      end
      if (rd_en && !bus_sel && !(wr_en && !bus_sel && wdata == 8'h0B)) m_show = 0;
      if (wr_en && bus_sel) begin
        case (m_phase)
          0: m_mask = wdata;
          1: begin
            m_base = wdata >> 3;
            m_phase = !m_single ? 2 : (m_mode ? 3 : 0);
          end
          2: m_phase = m_mode ? 3 : 0;
          default: begin m_aeoi = wdata[1]; m_phase = 0; end
        endcase
      end
      m_irq = (e != 0);
      m_irr = n_irr & 8'hFF; m_isr = n_isr & 8'hFF;
      m_reqq = irq_in;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check({tag, " irq_out"}, irq_out, m_irq);
      check({tag, " vec_out"}, vec_out, m_vec);
      check({tag, " rdata"}, rdata, m_rdata);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit sel, logic [7:0] v);
    @(negedge clk); bus_sel = sel; wdata = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(bit sel, output logic [7:0] v);
    @(negedge clk); bus_sel = sel; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0; v = vec_out;
  endtask

  initial begin
    logic [7:0] v;
    idle(4);
    rst = 1'b0;
    idle(1);
    tag = "R1";
    check("R1 irq_out", irq_out, 0);
    check("R1 vec_out", vec_out, 0);
    rd(1, v); check("R1 mask reset", v, 8'hFF);
    rd(0, v); check("R1 irr reset", v, 8'h00);

    tag = "R6";
    wr(1, 8'h00); rd(1, v); check("R6 mask load", v, 8'h00);

    tag = "R2";
    wr(0, 8'h12);
    wr(1, 8'h45);
    tag = "R3";
    wr(1, 8'hF0); rd(1, v); check("R3 mask after single setup", v, 8'hF0);

    tag = "R9";
    irq_in = 8'h22; idle(3);
    check("R9 irq raised", irq_out, 1);
    tag = "R10";
    ack(v); check("R10 vector line1", v, 8'h41);
    tag = "R7";
    wr(0, 8'h0B); rd(0, v); check("R7 isr read", v, 8'h02);
    rd(0, v); check("R7 back to irr", v, 8'h20);

    tag = "R9";
    @(negedge clk); irq_in = 8'h28; idle(3);
    check("R9 blocked by lower isr", irq_out, 0);
    tag = "R8";
    wr(0, 8'h61); idle(2);
    check("R8 specific eoi unblocks", irq_out, 1);
    ack(v); check("R10 vector line3", v, 8'h43);
    wr(0, 8'h20); wr(0, 8'h0B); rd(0, v); check("R8 eoi all clears isr", v, 8'h00);

    tag = "R11";
    wr(1, 8'hFF); ack(v); check("R11 spurious", v, 8'h47);
    rd(0, v); check("R11 irr untouched", v, 8'h20);

    tag = "R12";
    wr(1, 8'h00);
    @(negedge clk); irq_in = 8'h64; idle(3);
    ack(v); check("R12 lowest wins", v, 8'h42);
    ack(v); check("R12 nested blocked spurious", v, 8'h47);
    wr(0, 8'h20); ack(v); check("R12 next line5", v, 8'h45);
    wr(0, 8'h20); ack(v); check("R12 next line6", v, 8'h46);
    wr(0, 8'h20);

    tag = "R5";
    wr(0, 8'h11); wr(1, 8'h80);
    rd(1, v); check("R6 mask kept in setup", v, 8'h00);
    tag = "R4";
    wr(1, 8'h04);
    tag = "R5";
    wr(1, 8'h02); wr(1, 8'h00);
    @(negedge clk); irq_in = 8'h00; @(negedge clk); irq_in = 8'h10; idle(3);
    ack(v); check("R5 vector line4", v, 8'h84);
    wr(0, 8'h0B); rd(0, v); check("R5 auto eoi no isr", v, 8'h00);

    tag = "R4";
    wr(0, 8'h10); wr(1, 8'h90); wr(1, 8'h04); wr(1, 8'h0F);
    rd(1, v); check("R4 mask after link word", v, 8'h0F);
    ack(v); check("R4 spurious new base", v, 8'h97);
    idle(2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule